// File: doc/BRIEF.md
# JTAG Scan Command Engine

This block is a JTAG master that turns a stream of packed command bytes into activity on TCK, TMS and TDI. A register-bus side pushes 1, 2 or 4 bytes per write into a byte queue, lowest byte first. A sequencer drains the queue one byte at a time and decodes each byte as a command. It either clocks a short TMS pattern, or it reads a length byte and shifts a payload of up to 128 bits onto TDI. During that shift it can also gather TDO into 32-bit words for a read queue.

A separate one-hot chain-select register routes the pins to one chain, or to none. A status word shows the sequencer state, how full the byte queue is, and a sticky flag for any data that was lost. Firmware checks that the status word is all zero before it starts a new batch. It reads captured words through the read port.

Top module: `jtag_cmd_engine`

## Requirements
- R1: `wr_size` codes 0, 1 and 2 push 1, 2 and 4 bytes of `wr_data` into the byte queue, byte [7:0] first. Code 3 pushes nothing and sets no flag.
- R2: A write that needs more bytes than the queue has free is dropped whole. It sets the sticky lost-data flag (status bit 0), which only reset clears. With the default depth of 8, two 4-byte writes are accepted and a third one in the next cycle is rejected.
- R3: `status` is {busy, byte count saturated at 7, 27 zero bits, lost-data flag}. Busy is bit 31 and the count is bits 30:28. Busy is high from the cycle after a command byte is taken until the command has finished.
- R4: A command byte with bit 7 = 0 is a TMS command. It gives one TCK rise for each of bits [4:0], LSB first, with TMS equal to that bit. If bit 5 is set, one more rise follows with TMS = 1. TDI is 0 during these rises. Bit 6 is ignored, and the command takes no further bytes.
- R5: A command byte with bit 7 = 1 and bit 4 = 1 reads a length byte L next, using bits [6:0] and ignoring bit 7. It then shifts L+1 bits (1 to 128) from the next ceil((L+1)/8) bytes, LSB first, on TDI, with TMS = 0 at every rise. Any high bits of the last byte that are not used are thrown away.
- R6: A command byte with bit 7 = 1 and bit 4 = 0 produces no TCK rise and takes no further bytes.
- R7: If bit 2 of a shifting command byte is set, TDO is sampled at each TCK rise. The samples are packed LSB first into 32-bit words. A word is pushed when it holds 32 bits, or when the command ends, in which case the unused upper bits are zero. Without bit 2, nothing is pushed.
- R8: `rd_valid` shows that the read queue is not empty, and `rd_data` is its oldest word. `rd_en` removes that word. A word captured while the read queue (4 words by default) is full is lost and sets the lost-data flag.
- R9: TCK is high for exactly one clock and then low for at least one clock. TMS and TDI never change in the cycle in which TCK rises. TDO is sampled on the clock edge that raises TCK.
- R10: A `chain_wr` whose data has at most one bit set loads `chain_sel`. Any other value is ignored and the old selection is kept.
- R11: During reset and just after it, `tck`, `tms`, `tdi`, `chain_sel`, `status` and `rd_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte-queue write strobe |
| wr_size | input | 2 | Write size code: 0=1 byte, 1=2 bytes, 2=4 bytes, 3=none |
| wr_data | input | 32 | Write data, low byte enters first |
| rd_en | input | 1 | Remove the oldest captured word |
| rd_data | output | 32 | Oldest captured TDO word |
| rd_valid | output | 1 | Read queue not empty |
| chain_wr | input | 1 | Chain-select write strobe |
| chain_wdata | input | NUM_CHAINS | New chain selection |
| chain_sel | output | NUM_CHAINS | One-hot chain select |
| status | output | 32 | {busy, count[2:0], 27'b0, lost} |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the chain |
| tdo | input | 1 | Test data from the chain |

## Verification
A wrong decode or a bad bit counter shows up at the pins on the very next TCK rise: an extra rise, a missing one, or a wrong TMS/TDI level. The bench compares every rise with a queue of expected pin levels, so the fault is reported within one bit period. Byte-alignment faults, such as a payload byte not taken or taken twice, shift every later bit and also leave the queue count wrong once the engine goes idle. Capture-packing faults appear only when a word is read. The bench therefore reads out words after full, partial and overflowing captures.

// File: rtl/jce_pkg.sv
`timescale 1ns/1ps
package jce_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TMS,
      ST_LEN,
      ST_LOAD,
      ST_SHIFT
   } seq_state_t;

   localparam logic [1:0] SZ_ONE  = 2'd0;
   localparam logic [1:0] SZ_TWO  = 2'd1;
   localparam logic [1:0] SZ_FOUR = 2'd2;

   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         SZ_ONE:  return 3'd1;
         SZ_TWO:  return 3'd2;
         SZ_FOUR: return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/jce_byte_fifo.sv
`timescale 1ns/1ps
module jce_byte_fifo #(
   parameter int DEPTH = 8,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic [1:0]       wr_size,
   input  logic [31:0]      wr_data,
   input  logic             pop,
   output logic [7:0]       head,
   output logic             empty,
   output logic [CNT_W-1:0] count,
   output logic             drop
);
   import jce_pkg::*;

   localparam int PTR_W = $clog2(DEPTH);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 4) begin : g_bad_depth
      $error("jce_byte_fifo: DEPTH must be a power of two and at least 4");
   end

   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] rp, wp;
   logic [CNT_W-1:0] cnt;
   logic [2:0]       n_bytes;
   logic [CNT_W-1:0] free_slots;
   logic             accept, do_pop;

   always_comb begin
      n_bytes    = size_bytes(wr_size);
      free_slots = DEPTH_C - cnt;
      accept     = wr_req && (n_bytes != 3'd0) && (free_slots >= CNT_W'(n_bytes));
      drop       = wr_req && (n_bytes != 3'd0) && !accept;
      do_pop     = pop && (cnt != '0);
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < 4; i++) begin
         if (accept && (3'(i) < n_bytes)) begin
            mem[wp + PTR_W'(i)] <= wr_data[8*i +: 8];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         if (accept) wp <= wp + PTR_W'(n_bytes);
         if (do_pop) rp <= rp + PTR_W'(1);
         cnt <= cnt + (accept ? CNT_W'(n_bytes) : '0) - CNT_W'(do_pop);
      end
   end

   assign head  = mem[rp];
   assign empty = (cnt == '0);
   assign count = cnt;

   assert_drop_keeps_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> (cnt <= $past(cnt)))
      else $error("rejected write changed the queue count upward");

   assert_push_grows_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !do_pop) |=> (cnt == $past(cnt) + CNT_W'($past(n_bytes))))
      else $error("accepted write did not add its byte count");

   assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= DEPTH_C)
      else $error("byte queue count beyond depth");

endmodule

// File: rtl/jce_word_fifo.sv
`timescale 1ns/1ps
module jce_word_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         valid,
   output logic         drop
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("jce_word_fifo: DEPTH must be a power of two and at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] rp, wp;
   logic [CNT_W-1:0] cnt;
   logic             full, do_push, do_pop;

   always_comb begin
      full    = (cnt == DEPTH_C);
      do_push = push && !full;
      drop    = push && full;
      do_pop  = pop && (cnt != '0);
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + PTR_W'(1);
         if (do_pop)  rp <= rp + PTR_W'(1);
         cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   assign rdata = mem[rp];
   assign valid = (cnt != '0);

   assert_full_drop_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && !do_pop) |=> (cnt == $past(cnt)))
      else $error("word accepted into a full read queue");

   assert_pop_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (do_pop && !do_push) |=> (cnt == $past(cnt) - CNT_W'(1)))
      else $error("read did not remove a word");

endmodule

// File: rtl/jce_sequencer.sv
`timescale 1ns/1ps
module jce_sequencer #(
   parameter int LEN_FIELD_W = 7,
   parameter int WORD_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_avail,
   input  logic [7:0]        head,
   input  logic              tdo,
   output logic              pop,
   output logic              busy,
   output logic              tck,
   output logic              tms,
   output logic              tdi,
   output logic              cap_push,
   output logic [WORD_W-1:0] cap_word
);
   import jce_pkg::*;

   localparam int BL_W  = LEN_FIELD_W + 1;
   localparam int ACC_W = $clog2(WORD_W);

   if (LEN_FIELD_W < 1 || LEN_FIELD_W > 7) begin : g_bad_len
      $error("jce_sequencer: LEN_FIELD_W must be 1..7");
   end
   if (WORD_W < 8 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
      $error("jce_sequencer: WORD_W must be a power of two, at least 8");
   end

   seq_state_t        state;
   logic              ph;
   logic              tck_q, tms_q, tdi_q;
   logic [5:0]        tms_pat;
   logic [2:0]        tcnt;
   logic [BL_W-1:0]   bits_left;
   logic [7:0]        sreg;
   logic [2:0]        bidx;
   logic              cap_q;
   logic [WORD_W-1:0] acc, acc_next;
   logic [ACC_W-1:0]  acc_n;
   logic              acc_full, last_bit;
   logic              push_q;
   logic [WORD_W-1:0] word_q;

   always_comb begin
      acc_next = acc | (WORD_W'(tdo) << acc_n);
      acc_full = (acc_n == ACC_W'(WORD_W - 1));
      last_bit = (bits_left == BL_W'(1));
      pop      = byte_avail &&
                 (state == ST_IDLE || state == ST_LEN || state == ST_LOAD);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ph        <= 1'b0;
         tck_q     <= 1'b0;
         tms_q     <= 1'b0;
         tdi_q     <= 1'b0;
         tms_pat   <= '0;
         tcnt      <= '0;
         bits_left <= '0;
         sreg      <= '0;
         bidx      <= '0;
         cap_q     <= 1'b0;
         acc       <= '0;
         acc_n     <= '0;
         push_q    <= 1'b0;
         word_q    <= '0;
      end else begin
         push_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               tck_q <= 1'b0;
               if (byte_avail) begin
                  if (!head[7]) begin
                     tms_pat <= {1'b1, head[4:0]};
                     tcnt    <= head[5] ? 3'd6 : 3'd5;
                     ph      <= 1'b0;
                     state   <= ST_TMS;
                  end else if (head[4]) begin
                     cap_q <= head[2];
                     state <= ST_LEN;
                  end
               end
            end
            ST_TMS: begin
               if (!ph) begin
                  tck_q <= 1'b0;
                  tms_q <= tms_pat[0];
                  tdi_q <= 1'b0;
                  ph    <= 1'b1;
               end else begin
                  tck_q   <= 1'b1;
                  tms_pat <= tms_pat >> 1;
                  tcnt    <= tcnt - 3'd1;
                  ph      <= 1'b0;
                  if (tcnt == 3'd1) state <= ST_IDLE;
               end
            end
            ST_LEN: begin
               tck_q <= 1'b0;
               if (byte_avail) begin
                  bits_left <= {1'b0, head[LEN_FIELD_W-1:0]} + BL_W'(1);
                  state     <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               tck_q <= 1'b0;
               if (byte_avail) begin
                  sreg  <= head;
                  bidx  <= '0;
                  ph    <= 1'b0;
                  state <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (!ph) begin
                  tck_q <= 1'b0;
                  tdi_q <= sreg[0];
                  tms_q <= 1'b0;
                  ph    <= 1'b1;
               end else begin
                  tck_q     <= 1'b1;
                  ph        <= 1'b0;
                  sreg      <= sreg >> 1;
                  bidx      <= bidx + 3'd1;
                  bits_left <= bits_left - BL_W'(1);
                  if (cap_q) begin
                     if (acc_full || last_bit) begin
                        push_q <= 1'b1;
                        word_q <= acc_next;
                        acc    <= '0;
                        acc_n  <= '0;
                     end else begin
                        acc   <= acc_next;
                        acc_n <= acc_n + ACC_W'(1);
                     end
                  end
                  if (last_bit)            state <= ST_IDLE;
                  else if (bidx == 3'd7)   state <= ST_LOAD;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state != ST_IDLE);
   assign tck      = tck_q;
   assign tms      = tms_q;
   assign tdi      = tdi_q;
   assign cap_push = push_q;
   assign cap_word = word_q;

   assert_tck_one_cycle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tck_q |=> !tck_q)
      else $error("TCK held high for more than one clock");

   assert_pins_steady_at_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tck_q) |-> ($stable(tms_q) && $stable(tdi_q)))
      else $error("TMS or TDI moved together with the TCK rise");

   assert_tms_low_in_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT && tck_q) |-> !tms_q)
      else $error("TMS high during payload shift");

   assert_no_rise_outside_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tck_q) |-> ($past(state) == ST_TMS || $past(state) == ST_SHIFT))
      else $error("TCK rose outside a clocking command");

endmodule

// File: rtl/jtag_cmd_engine.sv
`timescale 1ns/1ps
module jtag_cmd_engine #(
   parameter int WFIFO_DEPTH = 8,
   parameter int RFIFO_DEPTH = 4,
   parameter int NUM_CHAINS  = 8,
   parameter int LEN_FIELD_W = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            wr_size,
   input  logic [31:0]           wr_data,
   input  logic                  rd_en,
   output logic [31:0]           rd_data,
   output logic                  rd_valid,
   input  logic                  chain_wr,
   input  logic [NUM_CHAINS-1:0] chain_wdata,
   output logic [NUM_CHAINS-1:0] chain_sel,
   output logic [31:0]           status,
   output logic                  tck,
   output logic                  tms,
   output logic                  tdi,
   input  logic                  tdo
);
   localparam int CNT_W  = $clog2(WFIFO_DEPTH + 1);
   localparam int WORD_W = 32;

   if (NUM_CHAINS < 1 || NUM_CHAINS > 32) begin : g_bad_chains
      $error("jtag_cmd_engine: NUM_CHAINS must be 1..32");
   end

   logic [7:0]        head;
   logic              empty, pop, wdrop, rdrop, busy;
   logic [CNT_W-1:0]  wcnt;
   logic [2:0]        cnt_field;
   logic              cap_push;
   logic [WORD_W-1:0] cap_word;
   logic              lost_q;
   logic [NUM_CHAINS-1:0] chain_q;
   logic              chain_ok;

   jce_byte_fifo #(.DEPTH(WFIFO_DEPTH), .CNT_W(CNT_W)) u_wq (
      .clk(clk), .rst_n(rst_n),
      .wr_req(wr_en), .wr_size(wr_size), .wr_data(wr_data),
      .pop(pop), .head(head), .empty(empty), .count(wcnt), .drop(wdrop)
   );

   jce_sequencer #(.LEN_FIELD_W(LEN_FIELD_W), .WORD_W(WORD_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .byte_avail(!empty), .head(head), .tdo(tdo),
      .pop(pop), .busy(busy),
      .tck(tck), .tms(tms), .tdi(tdi),
      .cap_push(cap_push), .cap_word(cap_word)
   );

   jce_word_fifo #(.DEPTH(RFIFO_DEPTH), .W(WORD_W)) u_rq (
      .clk(clk), .rst_n(rst_n),
      .push(cap_push), .wdata(cap_word),
      .pop(rd_en), .rdata(rd_data), .valid(rd_valid), .drop(rdrop)
   );

   if (CNT_W > 3) begin : g_cnt_sat
      assign cnt_field = (wcnt > CNT_W'(7)) ? 3'd7 : wcnt[2:0];
   end else begin : g_cnt_pad
      assign cnt_field = 3'(wcnt);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)             lost_q <= 1'b0;
      else if (wdrop || rdrop) lost_q <= 1'b1;
   end

   assign chain_ok = ((chain_wdata & (chain_wdata - NUM_CHAINS'(1))) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)                   chain_q <= '0;
      else if (chain_wr && chain_ok) chain_q <= chain_wdata;
   end

   assign chain_sel = chain_q;
   assign status    = {busy, cnt_field, 27'd0, lost_q};

   assert_chain_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chain_sel))
      else $error("more than one chain selected");

   assert_lost_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lost_q |=> lost_q)
      else $error("lost-data flag cleared without reset");

   assert_lost_on_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wdrop || rdrop) |=> lost_q)
      else $error("dropped data did not raise the lost flag");

endmodule

// File: tb/tb_jtag_cmd_engine.sv
`timescale 1ns/1ps
module tb_jtag_cmd_engine;
   localparam int NCH = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_size = 2'd0;
   logic [31:0] wr_data = '0;
   logic rd_en = 1'b0;
   logic [31:0] rd_data;
   logic rd_valid;
   logic chain_wr = 1'b0;
   logic [NCH-1:0] chain_wdata = '0;
   logic [NCH-1:0] chain_sel;
   logic [31:0] status;
   logic tck, tms, tdi;
   logic tdo_r = 1'b0;

   always #5 clk = ~clk;

   jtag_cmd_engine dut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_size(wr_size), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
      .chain_wr(chain_wr), .chain_wdata(chain_wdata), .chain_sel(chain_sel),
      .status(status), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo_r)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Reference model: expected pin levels per TCK rise {is_tms, tms, tdi, cap, last}
   logic [4:0]  exp_q[$];
   logic [31:0] exp_words[$];
   bit          mon_en = 1'b1;
   int          tdo_idx = 0;
   logic [31:0] m_acc = '0;
   int          m_n = 0;
   logic        prev_tck = 1'b0, prev_tms = 1'b0, prev_tdi = 1'b0;
   logic [4:0]  e;

   function automatic logic tdo_pat(input int i);
      return logic'(((i % 5) < 2) != (((i / 8) % 2) == 1));
   endfunction

   always @(negedge clk) begin
      if (rst_n && mon_en) begin
         if (tck && prev_tck) chk(1'b0, "R9", "TCK high two clocks", 32'd1, 32'd0);
         if (tck && !prev_tck) begin
            chk(tms == prev_tms && tdi == prev_tdi, "R9", "pins moved at rise",
                {30'd0, tms, tdi}, {30'd0, prev_tms, prev_tdi});
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6", "unexpected TCK rise", 32'd1, 32'd0);
            end else begin
               e = exp_q.pop_front();
               chk(tms == e[3], e[4] ? "R4" : "R5", "TMS at rise", {31'd0, tms}, {31'd0, e[3]});
               chk(tdi == e[2], e[4] ? "R4" : "R5", "TDI at rise", {31'd0, tdi}, {31'd0, e[2]});
               if (e[1]) begin
                  m_acc[m_n] = tdo_r;
                  m_n++;
                  if (m_n == 32 || e[0]) begin
                     if (exp_words.size() < 4) exp_words.push_back(m_acc);
                     m_acc = '0;
                     m_n = 0;
                  end
               end
            end
            tdo_idx++;
            tdo_r = tdo_pat(tdo_idx);
         end
      end
      prev_tck = tck;
      prev_tms = tms;
      prev_tdi = tdi;
   end

   task automatic exp_tms(input logic [7:0] c);
      for (int i = 0; i < 5; i++) exp_q.push_back({1'b1, c[i], 1'b0, 1'b0, 1'b0});
      if (c[5]) exp_q.push_back({1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
   endtask

   task automatic exp_tdi(input int nbits, input logic [127:0] p, input bit cap);
      for (int i = 0; i < nbits; i++)
         exp_q.push_back({1'b0, 1'b0, p[i], cap, (i == nbits - 1)});
   endtask

   task automatic wr(input logic [1:0] sz, input logic [31:0] d);
      int k;
      k = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      @(negedge clk);
      while (int'(status[30:28]) > 7 - k) @(negedge clk);
      wr_en = 1'b1; wr_size = sz; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (!(status[31:28] == 4'd0 && exp_q.size() == 0));
      @(negedge clk);
   endtask

   task automatic rd_word(input string req);
      logic [31:0] w;
      @(negedge clk);
      chk(rd_valid == 1'b1, req, "read queue not empty", {31'd0, rd_valid}, 32'd1);
      if (exp_words.size() > 0) begin
         w = exp_words.pop_front();
         chk(rd_data == w, req, "captured word", rd_data, w);
      end else begin
         chk(1'b0, req, "model has no word", rd_data, 32'd0);
      end
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic chain(input logic [NCH-1:0] v, input logic [NCH-1:0] expv);
      @(negedge clk);
      chain_wr = 1'b1; chain_wdata = v;
      @(negedge clk);
      chain_wr = 1'b0;
      chk(chain_sel == expv, "R10", "chain select", 32'(chain_sel), 32'(expv));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(tck == 0 && tms == 0 && tdi == 0, "R11", "pins in reset", {29'd0, tck, tms, tdi}, 32'd0);
      chk(status == 32'd0, "R11", "status in reset", status, 32'd0);
      chk(chain_sel == '0, "R11", "chain select in reset", 32'(chain_sel), 32'd0);
      chk(rd_valid == 1'b0, "R11", "read valid in reset", {31'd0, rd_valid}, 32'd0);
      exp_q.delete();
      exp_words.delete();
      m_acc = '0; m_n = 0;
      rst_n = 1'b1;
      @(negedge clk);
      chk(status == 32'd0, "R11", "status after reset", status, 32'd0);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R11 watchdog expired: actual=%h expected=%h", 32'd1, 32'd0);
         finish_run();
      end
   end

   initial begin
      logic [127:0] big;
      tdo_r = tdo_pat(0);
      do_reset();

      // R10 chain selection
      chain(8'h80, 8'h80);
      chain(8'h03, 8'h80);
      chain(8'h00, 8'h00);
      chain(8'h04, 8'h04);

      // R4 TMS commands, including extension bit and ignored bit 6
      exp_tms(8'h3F); wr(2'd0, 32'h3F);
      exp_tms(8'h52); wr(2'd0, 32'h52);
      exp_tms(8'h22); wr(2'd0, 32'h22);
      wait_idle();
      chk(status == 32'd0, "R3", "idle status", status, 32'd0);

      // R6 shift command without payload flag, then a TMS command
      wr(2'd0, 32'h80);
      exp_tms(8'h01); wr(2'd0, 32'h01);
      wait_idle();
      chk(exp_q.size() == 0, "R6", "all expected rises seen", exp_q.size(), 32'd0);

      // R1 reserved size code pushes nothing
      wr(2'd3, 32'hFFFF_FF3F);
      chk(status[30:28] == 3'd0, "R1", "reserved size ignored", {29'd0, status[30:28]}, 32'd0);
      chk(status[0] == 1'b0, "R1", "reserved size sets no flag", {31'd0, status[0]}, 32'd0);
      wait_idle();

      // R5 / R1 payload shifts without capture
      exp_tdi(12, 128'hABCD, 1'b0);
      wr(2'd1, {16'd0, 8'd11, 8'h90}); wr(2'd1, 32'hABCD);
      exp_tdi(12, 128'h1234, 1'b0);
      wr(2'd1, {16'd0, 8'h8B, 8'h90}); wr(2'd1, 32'h1234);
      exp_tdi(3, 128'hFD, 1'b0);
      wr(2'd1, {16'd0, 8'd2, 8'h90}); wr(2'd0, 32'hFD);
      wait_idle();
      chk(rd_valid == 1'b0, "R7", "no capture without bit 2", {31'd0, rd_valid}, 32'd0);

      // R7 full-word capture
      exp_tdi(32, 128'h12345678, 1'b1);
      wr(2'd1, {16'd0, 8'd31, 8'h94}); wr(2'd2, 32'h12345678);
      wait_idle();
      rd_word("R7");
      @(negedge clk);
      chk(rd_valid == 1'b0, "R8", "queue empty after read", {31'd0, rd_valid}, 32'd0);

      // R7 partial word, zero padded
      exp_tdi(5, 128'h1F, 1'b1);
      wr(2'd1, {16'd0, 8'd4, 8'h94}); wr(2'd0, 32'h1F);
      wait_idle();
      rd_word("R7");

      // R5 maximum length with capture, then R8 read-queue overflow
      big = {32'hDEADBEEF, 32'h0BADF00D, 32'hCAFEF00D, 32'h13579BDF};
      exp_tdi(128, big, 1'b1);
      wr(2'd1, {16'd0, 8'd127, 8'h94});
      for (int w = 0; w < 4; w++) wr(2'd2, big[32*w +: 32]);
      wait_idle();
      chk(status[0] == 1'b0, "R8", "no loss with 4 words", {31'd0, status[0]}, 32'd0);
      exp_tdi(5, 128'h0A, 1'b1);
      wr(2'd1, {16'd0, 8'd4, 8'h94}); wr(2'd0, 32'h0A);
      wait_idle();
      repeat (2) @(negedge clk);
      chk(status[0] == 1'b1, "R8", "loss flag on full read queue", {31'd0, status[0]}, 32'd1);
      for (int w = 0; w < 4; w++) rd_word("R5");
      @(negedge clk);
      chk(rd_valid == 1'b0, "R8", "overflow word not stored", {31'd0, rd_valid}, 32'd0);

      // R2 / R3 write-queue fill and drop, monitor off
      do_reset();
      mon_en = 1'b0;
      @(negedge clk);
      wr_en = 1'b1; wr_size = 2'd2; wr_data = {8'hAA, 8'hAA, 8'd127, 8'h90};
      @(negedge clk);
      chk(status == 32'h4000_0000, "R3", "four bytes queued, idle", status, 32'h4000_0000);
      @(negedge clk);
      chk(status == 32'hF000_0000, "R3", "busy with seven bytes", status, 32'hF000_0000);
      @(negedge clk);
      wr_en = 1'b0;
      chk(status == 32'hE000_0001, "R2", "third write dropped", status, 32'hE000_0001);
      repeat (5) @(negedge clk);
      chk(status[0] == 1'b1, "R2", "loss flag sticky", {31'd0, status[0]}, 32'd1);
      do_reset();
      mon_en = 1'b1;
      @(negedge clk);

      // post-reset sanity
      exp_tms(8'h1F); wr(2'd0, 32'h1F);
      wait_idle();
      chk(exp_q.size() == 0, "R4", "post-reset TMS command", exp_q.size(), 32'd0);

      done = 1'b1;
      finish_run();
   end
endmodule